// File: doc/BRIEF.md
# Multiplexed Seven-Segment Shift Driver

This block refreshes four multiplexed seven-segment digits through an external 8-bit serial-in, latched-output shift register. It keeps four 5-bit digit words. Each word has a 4-bit glyph code in bits 3..0 and a decimal-point flag in bit 4. On every refresh tick it picks the next digit and builds one byte. The byte holds the glyph code in its upper nibble and a one-hot digit select in its lower nibble. The block sends the byte serially, MSB first, and then pulses the latch.

One pin does two jobs: it is the storage-register clock and also the active-high output disable of the external part. The pin rises before shifting so that the display is dark while the data changes. After the last bit it drops, rises again to transfer the byte, and drops once more to show the new digit. The decimal point is not sent in the byte. Once the latch sequence is done, the shared serial line is left low when the current digit's point is lit, and high otherwise.

A `suspend` input stops refreshing while an upstream writer prepares new digit words. When `suspend` falls, the block copies the `digit_words` input into its word store, resets the digit index to 0 and starts a frame at once.

The control FSM has these states:
- `ST_IDLE` waits for a start request. It moves to `ST_BLANK` when a start is pending, `suspend` is low and no release is happening in the same cycle.
- `ST_BLANK` raises the latch and moves to `ST_BIT_LO`.
- `ST_BIT_LO` presents a bit and drives the shift clock low. It moves to `ST_BIT_HI`.
- `ST_BIT_HI` raises the shift clock. It returns to `ST_BIT_LO` until 8 bits have been sent, then moves to `ST_XFER_LO`.
- `ST_XFER_LO` (latch low) moves to `ST_XFER_HI` (latch high, which transfers the byte).
- `ST_XFER_HI` moves to `ST_ENABLE`, which drops the latch to enable the outputs.
- `ST_ENABLE` moves to `ST_DOT`, which sets the decimal-point level on the serial line.
- `ST_DOT` returns to `ST_IDLE`.

Every transition waits for a phase strobe, so each pin level is held for at least `PHASE_CLKS` clocks.

Top module: `segmux_driver`

## Requirements
- R1: Each digit word is 5 bits: bits 3..0 are the glyph code and bit 4 is the decimal-point flag. Word i occupies `digit_words[5*i+4 : 5*i]`.
- R2: Successive frames show digit indices 0, 1, 2, 3 and then wrap to 0.
- R3: A frame sends exactly 8 bits, MSB first. The byte is {glyph code, 4'b0001 << index}. Each bit is presented while `ser_clk` is low and is sampled on the rising edge of `ser_clk`.
- R4: `latch_oe` rises before the first shift edge and stays high across all 8 shift-clock edges. After the shifting it goes low, then high (which transfers the byte), then low.
- R5: Between frames, `ser_data` is low if the digit just shown has its decimal-point flag set, and high otherwise. After reset the line is high.
- R6: Frames start every `TICK_CLKS*REFRESH_TICKS` clocks. The defaults are 1000 and 75: 600 us at 125 MHz, which is 75 ticks of an 8 us timebase.
- R7: No level on `ser_clk` lasts less than `PHASE_CLKS` clocks.
- R8: Reset loads the words with glyph codes 4, 3, 2, 1 for indices 0 to 3, with the decimal point set only on index 3. The first frame (index 0) starts within `PHASE_CLKS+3` clocks of reset release. During reset, `latch_oe` is 0, `ser_clk` is 1 and `ser_data` is 1.
- R9: No frame starts while `suspend` is high. A frame already in progress completes. On release, `digit_words` is captured and the next frame shows index 0 of the new words. If the block is idle, that frame starts within `PHASE_CLKS+3` clocks, and the refresh period restarts from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| digit_words | input | 20 | Four 5-bit digit words, captured when `suspend` falls |
| suspend | input | 1 | High holds off new frames |
| ser_data | output | 1 | Serial data, and decimal-point level between frames |
| ser_clk | output | 1 | Shift clock (data sampled on rising edge) |
| latch_oe | output | 1 | Storage clock and active-high output disable |

## Verification
A wrong digit index or wrap appears in the first byte transferred after the fault. It shows up as a select nibble that is not one-hot, or that is out of sequence, within one refresh period. A miscounted bit counter shows as a frame with more or fewer than 8 shift-clock edges, or as a byte shifted by one position, which is visible at the very next latch. A lost or stale decimal-point flag, or a pending-start flag stuck high or low, shows within one frame. It appears as the wrong idle level on the serial line, or as frames arriving off the exact refresh period or during suspend.

// File: rtl/segmux_pkg.sv
package segmux_pkg;

    localparam int NUM_DIGITS = 4;
    localparam int CODE_W     = 4;
    localparam int WORD_W     = CODE_W + 1;
    localparam int IDX_W      = $clog2(NUM_DIGITS);
    localparam int BYTE_W     = CODE_W + NUM_DIGITS;
    localparam int BITC_W     = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BLANK,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_XFER_LO,
        ST_XFER_HI,
        ST_ENABLE,
        ST_DOT
    } seg_state_t;

    // Power-up content: codes count down from NUM_DIGITS, point on the last word.
    function automatic logic [WORD_W-1:0] boot_word(input int idx);
        logic [WORD_W-1:0] w;
        w = WORD_W'(NUM_DIGITS - idx);
        w[WORD_W-1] = (idx == NUM_DIGITS - 1);
        return w;
    endfunction

endpackage

// File: rtl/segmux_timebase.sv
module segmux_timebase #(
    parameter int PHASE_CLKS    = 125,
    parameter int TICK_CLKS     = 1000,
    parameter int REFRESH_TICKS = 75
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic phase_en,
    output logic refresh_tick
);

    localparam int PERIOD = TICK_CLKS * REFRESH_TICKS;
    localparam int PW     = $clog2(PHASE_CLKS + 1);
    localparam int RW     = $clog2(PERIOD + 1);
    localparam logic [PW-1:0] P_LAST = PW'(PHASE_CLKS - 1);
    localparam logic [RW-1:0] R_LAST = RW'(PERIOD - 1);

    logic [PW-1:0] pcnt_q;
    logic [RW-1:0] rcnt_q;

    assign phase_en     = (pcnt_q == P_LAST);
    assign refresh_tick = (rcnt_q == R_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            rcnt_q <= '0;
        end else if (restart) begin
            pcnt_q <= '0;
            rcnt_q <= '0;
        end else begin
            pcnt_q <= phase_en ? '0 : pcnt_q + 1'b1;
            rcnt_q <= refresh_tick ? '0 : rcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/segmux_digit_store.sv
module segmux_digit_store
    import segmux_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [NUM_DIGITS*WORD_W-1:0] words_in,
    input  logic [IDX_W-1:0]             sel_idx,
    output logic [WORD_W-1:0]            word_out
);

    logic [WORD_W-1:0] word_q [NUM_DIGITS];

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[g] <= boot_word(g);
            end else if (load) begin
                word_q[g] <= words_in[g*WORD_W +: WORD_W];
            end
        end
    end

    assign word_out = word_q[sel_idx];

endmodule

// File: rtl/segmux_serializer.sv
module segmux_serializer
    import segmux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_en,
    input  logic              refresh_tick,
    input  logic              release_evt,
    input  logic              suspend,
    input  logic [WORD_W-1:0] word,
    output logic [IDX_W-1:0]  idx,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              latch_oe
);

    localparam logic [BITC_W-1:0] LAST_BIT = BITC_W'(BYTE_W - 1);

    seg_state_t         state_q, state_d;
    logic [BYTE_W-1:0]  shreg_q;
    logic [BITC_W-1:0]  bitcnt_q;
    logic [IDX_W-1:0]   idx_q;
    logic               dp_q;
    logic               dot_line_q;
    logic               pending_q;
    logic               start;

    assign start = (state_q == ST_IDLE) && phase_en && pending_q
                   && !suspend && !release_evt;
    assign idx   = idx_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)    state_d = ST_BLANK;
            ST_BLANK:   if (phase_en) state_d = ST_BIT_LO;
            ST_BIT_LO:  if (phase_en) state_d = ST_BIT_HI;
            ST_BIT_HI:  if (phase_en) state_d = (bitcnt_q == LAST_BIT) ? ST_XFER_LO : ST_BIT_LO;
            ST_XFER_LO: if (phase_en) state_d = ST_XFER_HI;
            ST_XFER_HI: if (phase_en) state_d = ST_ENABLE;
            ST_ENABLE:  if (phase_en) state_d = ST_DOT;
            ST_DOT:     if (phase_en) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            bitcnt_q   <= '0;
            idx_q      <= '0;
            dp_q       <= 1'b0;
            dot_line_q <= 1'b1;
            pending_q  <= 1'b1;
        end else begin
            pending_q <= (pending_q && !start) || refresh_tick || release_evt;
            if (start) begin
                shreg_q  <= {word[CODE_W-1:0], NUM_DIGITS'(1) << idx_q};
                dp_q     <= word[WORD_W-1];
                bitcnt_q <= '0;
            end else if (state_q == ST_BIT_HI && phase_en) begin
                shreg_q  <= shreg_q << 1;
                bitcnt_q <= bitcnt_q + 1'b1;
            end
            if (release_evt)  idx_q <= '0;
            else if (start)   idx_q <= idx_q + 1'b1;
            if (state_q == ST_ENABLE && phase_en) dot_line_q <= !dp_q;
        end
    end

    // Pin decode
    always_comb begin
        latch_oe = 1'b0;
        ser_clk  = 1'b1;
        ser_data = dot_line_q;
        unique case (state_q)
            ST_BLANK:   latch_oe = 1'b1;
            ST_BIT_LO: begin
                latch_oe = 1'b1;
                ser_clk  = 1'b0;
                ser_data = shreg_q[BYTE_W-1];
            end
            ST_BIT_HI: begin
                latch_oe = 1'b1;
                ser_data = shreg_q[BYTE_W-1];
            end
            ST_XFER_HI: latch_oe = 1'b1;
            default: ;
        endcase
    end

    p_shift_rise_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> latch_oe);

    p_shift_fall_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk) |-> latch_oe);

    p_select_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK) |-> ($countones(shreg_q[NUM_DIGITS-1:0]) == 1));

    p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> $past(phase_en));

    p_no_start_suspended_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && suspend) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/segmux_driver.sv
module segmux_driver
    import segmux_pkg::*;
#(
    parameter int PHASE_CLKS    = 125,
    parameter int TICK_CLKS     = 1000,
    parameter int REFRESH_TICKS = 75
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [19:0] digit_words,
    input  logic        suspend,
    output logic        ser_data,
    output logic        ser_clk,
    output logic        latch_oe
);

    logic              suspend_q;
    logic              release_evt;
    logic              phase_en;
    logic              refresh_tick;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) suspend_q <= 1'b0;
        else        suspend_q <= suspend;
    end

    assign release_evt = suspend_q && !suspend;

    segmux_timebase #(
        .PHASE_CLKS   (PHASE_CLKS),
        .TICK_CLKS    (TICK_CLKS),
        .REFRESH_TICKS(REFRESH_TICKS)
    ) u_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (release_evt),
        .phase_en    (phase_en),
        .refresh_tick(refresh_tick)
    );

    segmux_digit_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (release_evt),
        .words_in(digit_words),
        .sel_idx (idx),
        .word_out(word)
    );

    segmux_serializer u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_en    (phase_en),
        .refresh_tick(refresh_tick),
        .release_evt (release_evt),
        .suspend     (suspend),
        .word        (word),
        .idx         (idx),
        .ser_data    (ser_data),
        .ser_clk     (ser_clk),
        .latch_oe    (latch_oe)
    );

endmodule

// File: tb/segmux_driver_tb.sv
`timescale 1ns/1ps
module segmux_driver_tb;

    localparam int PHASE  = 2;
    localparam int TICKC  = 2;
    localparam int RTICKS = 75;
    localparam int PERIOD = TICKC * RTICKS;

    // Stimulus table: word i of each vector; expected bytes derive from R1/R3.
    localparam logic [4:0] VEC [4][4] = '{
        '{5'h09, 5'h17, 5'h00, 5'h1F},
        '{5'h0A, 5'h0B, 5'h0C, 5'h0D},
        '{5'h1F, 5'h1F, 5'h1F, 5'h1F},
        '{5'h15, 5'h0E, 5'h11, 5'h06}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] digit_words = '0;
    logic        suspend = 1'b0;
    logic        ser_data, ser_clk, latch_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    segmux_driver #(
        .PHASE_CLKS(PHASE), .TICK_CLKS(TICKC), .REFRESH_TICKS(RTICKS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .digit_words(digit_words), .suspend(suspend),
        .ser_data(ser_data), .ser_clk(ser_clk), .latch_oe(latch_oe)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // External shift register model and frame log
    logic [7:0] sr = '0;
    logic [7:0] byte_log [64];
    logic       dot_log  [64];
    int         start_cyc [64];
    int         bits_log [64];
    int         fidx = 0, rises = 0, nbits = 0, run_len = 0;
    int         gate_viol = 0, hold_viol = 0;
    logic       prev_sc = 1'b1, prev_lt = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            run_len = run_len + 1;
            if (ser_clk != prev_sc) begin
                if (run_len < PHASE) hold_viol = hold_viol + 1;
                run_len = 0;
                if (!latch_oe) gate_viol = gate_viol + 1;
                if (ser_clk) begin
                    sr = {sr[6:0], ser_data};
                    nbits = nbits + 1;
                end
            end
            if (latch_oe && !prev_lt) begin
                if (rises % 2 == 0) begin
                    if (fidx < 64) start_cyc[fidx] = cyc;
                    if (fidx > 0 && fidx <= 64) dot_log[fidx-1] = ser_data;
                    nbits = 0;
                end else begin
                    if (fidx < 64) begin
                        byte_log[fidx] = sr;
                        bits_log[fidx] = nbits;
                    end
                    fidx = fidx + 1;
                end
                rises = rises + 1;
            end
            prev_sc = ser_clk;
            prev_lt = latch_oe;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_frames(input int target);
        for (int k = 0; k < 5000 && fidx < target; k++) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] exp_byte(input logic [4:0] w, input int i);
        return {w[3:0], 4'(1 << i)};
    endfunction

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base, hold, rel_cyc;
        logic [4:0] nw [4];
        repeat (5) @(negedge clk);
        check("R8 reset latch_oe", latch_oe, 0);
        check("R8 reset ser_clk", ser_clk, 1);
        check("R5 reset ser_data", ser_data, 1);
        rel_cyc = cyc;
        rst_n = 1'b1;

        // Boot content frames
        wait_frames(4);
        repeat (20) @(negedge clk);
        check("R5 idle low after dp digit", ser_data, 0);
        wait_frames(6);
        check("R8 boot frame0", byte_log[0], 8'h41);
        check("R8 boot frame1", byte_log[1], 8'h32);
        check("R8 boot frame2", byte_log[2], 8'h24);
        check("R8 boot frame3", byte_log[3], 8'h18);
        check("R2 wrap to index0", byte_log[4], 8'h41);
        check("R5 dot frame0", dot_log[0], 1);
        check("R5 dot frame3", dot_log[3], 0);
        check("R6 period", start_cyc[1] - start_cyc[0], PERIOD);
        check("R8 first start latency", int'(start_cyc[0] - rel_cyc <= PHASE + 3), 1);

        // Table walk: suspend, load, release
        for (int v = 0; v < 4; v++) begin
            @(negedge clk) suspend = 1'b1;
            repeat (60) @(posedge clk);
            hold = fidx;
            repeat (2 * PERIOD + 20) @(posedge clk);
            @(negedge clk);
            check("R9 no frames while suspended", fidx, hold);
            check("R9 latch low while suspended", latch_oe, 0);
            digit_words = {VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]};
            base = fidx;
            rel_cyc = cyc;
            suspend = 1'b0;
            wait_frames(base + 5);
            for (int i = 0; i < 4; i++) begin
                check($sformatf("R1 R3 vec%0d byte idx%0d", v, i), byte_log[base+i], exp_byte(VEC[v][i], i));
                check($sformatf("R5 vec%0d dot idx%0d", v, i), dot_log[base+i], !VEC[v][i][4]);
                check($sformatf("R3 vec%0d bit count idx%0d", v, i), bits_log[base+i], 8);
            end
            check("R2 vec wrap", byte_log[base+4], exp_byte(VEC[v][0], 0));
            check("R9 release start latency", int'(start_cyc[base] - rel_cyc <= PHASE + 3), 1);
            check("R6 period after release", start_cyc[base+1] - start_cyc[base], PERIOD);
        end

        // Release during a frame: current frame finishes, next shows new index 0
        nw = '{5'h03, 5'h05, 5'h07, 5'h09};
        hold = rises;
        for (int k = 0; k < 1000 && rises == hold; k++) @(posedge clk);
        @(negedge clk);
        base = fidx;
        suspend = 1'b1;
        digit_words = {nw[3], nw[2], nw[1], nw[0]};
        repeat (4) @(negedge clk);
        suspend = 1'b0;
        wait_frames(base + 3);
        check("R9 mid-frame release idx0", byte_log[base+1], exp_byte(nw[0], 0));
        check("R9 mid-frame release idx1", byte_log[base+2], exp_byte(nw[1], 1));

        check("R4 shift edges only while latch high", gate_viol, 0);
        check("R7 shift clock phase width", hold_viol, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule